// File: doc/BRIEF.md
# Video Port Interrupt Status Register

This block collects interrupt events from a video capture and display port into one status word. Single-cycle strobes from the capture path, the display path, the general-purpose pin logic and the time-clock logic each set a sticky bit at a fixed position. Software clears a bit by writing a 1 to it. A companion enable word selects which status bits drive the one active-high, level-sensitive interrupt line.

Two status bits are produced inside the block rather than taken straight from a strobe. The missed-acknowledge bit is set when a new gating field or frame begins while any of the three display-done flag levels (first field, second field, whole frame) is still high. The time-clock tick and compare-match bits are accepted only when the capture mode is time-clock capture and the matching enable is on. In every other capture mode they stay at 0.

The register port is a plain single-cycle strobe interface. A write takes effect at the clock edge where `wr_en` is high. A read is a combinational select of the stored word. The interface has no handshake and never stalls, so it applies no back-pressure.

Top module: `vport_irq_stat`

## Requirements
- R1: After reset, the status word, the enable word and `irq` are all 0.
- R2: A one-cycle strobe on `ev_ovr_b`, `ev_gpio`, `ev_disp_done` or `ev_disp_under` sets status bit 17, 16, 13 or 12 respectively at that clock edge. The bit then stays set.
- R3: Status bit 14 is set at an edge where `fld_start` is high and at least one of `fld1_done`, `fld2_done` or `frm_done` is high. A `fld_start` with all three flags low leaves bit 14 unchanged.
- R4: Status bit 11 is set by `ev_tick` only when `cap_mode` is 3 (time-clock capture) and `tick_en` is 1. In modes 0, 1 and 2, or with `tick_en` at 0, the strobe has no effect.
- R5: Status bit 10 is set by `ev_cmp` only when `cap_mode` is 3 and `cmp_en` is 1. Otherwise the strobe has no effect.
- R6: A write with `wr_sel`=0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged.
- R7: If a set condition and a write-1 clear reach the same status bit at the same edge, the bit ends up set.
- R8: Only bits 10 to 14, 16 and 17 exist. All other bits of the status word and of the enable word, including the reserved bits 15, 9 and 8, always read 0. Writes to those bits are ignored.
- R9: `irq` is 1 exactly when some bit is set in both the status word and the enable word. It reflects the stored words with no extra register stage.
- R10: A write with `wr_sel`=1 loads the enable word from `wr_data`. `rd_sel`=1 reads the enable word back, and `rd_sel`=0 reads the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (write-1-clear), 1 enable word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 status, 1 enable word |
| rd_data | output | 32 | Selected word |
| ev_ovr_b | input | 1 | Channel-B capture overrun strobe |
| ev_gpio | input | 1 | General-purpose pin event strobe |
| ev_disp_done | input | 1 | Display complete strobe |
| ev_disp_under | input | 1 | Display FIFO under-run strobe |
| ev_tick | input | 1 | Time-clock tick count reached |
| ev_cmp | input | 1 | Time clock reached its compare value |
| cap_mode | input | 2 | Capture mode: 0 BT.656, 1 Y/C, 2 raw, 3 time-clock |
| tick_en | input | 1 | Tick interrupt enable |
| cmp_en | input | 1 | Compare-match interrupt enable |
| fld1_done | input | 1 | First-field-displayed flag level |
| fld2_done | input | 1 | Second-field-displayed flag level |
| frm_done | input | 1 | Frame-displayed flag level |
| fld_start | input | 1 | Start of the next gating field or frame |
| irq | output | 1 | Combined level interrupt |

## Verification
Every status and enable change becomes visible at the first clock edge that samples the strobe or the write. The change then appears on `rd_data` and `irq` with no further latency, because the read select and the interrupt OR are combinational. The bench changes its inputs 1 ns after a rising edge. After the next rising edge it advances its own model of the two words. It then waits 1 ns and compares the status word, the enable word (by switching `rd_sel`) and `irq`, all before the following falling edge.

// File: rtl/vport_irq_pkg.sv
package vport_irq_pkg;
  localparam int REG_W = 32;

  // Bit positions that software decodes
  localparam int B_TCMP  = 10;
  localparam int B_TICK  = 11;
  localparam int B_UNDER = 12;
  localparam int B_DONE  = 13;
  localparam int B_MISS  = 14;
  localparam int B_GPIO  = 16;
  localparam int B_OVRB  = 17;

  localparam logic [REG_W-1:0] IMPL_BITS =
    (REG_W'(1) << B_TCMP) | (REG_W'(1) << B_TICK) | (REG_W'(1) << B_UNDER) |
    (REG_W'(1) << B_DONE) | (REG_W'(1) << B_MISS) | (REG_W'(1) << B_GPIO)  |
    (REG_W'(1) << B_OVRB);

  typedef enum logic [1:0] {
    CAP_BT656 = 2'd0,
    CAP_YC    = 2'd1,
    CAP_RAW   = 2'd2,
    CAP_TC    = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/vport_irq_cell.sv
module vport_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // A set beats a clear at the same edge so no event is dropped
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/vport_irq_qual.sv
module vport_irq_qual
  import vport_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         ev_ovr_b,
  input  logic         ev_gpio,
  input  logic         ev_disp_done,
  input  logic         ev_disp_under,
  input  logic         ev_tick,
  input  logic         ev_cmp,
  input  logic [1:0]   cap_mode,
  input  logic         tick_en,
  input  logic         cmp_en,
  input  logic         fld1_done,
  input  logic         fld2_done,
  input  logic         frm_done,
  input  logic         fld_start,
  output logic [W-1:0] set_vec
);
  logic tc_mode;
  logic done_pending;

  assign tc_mode      = (cap_mode_e'(cap_mode) == CAP_TC);
  assign done_pending = fld1_done | fld2_done | frm_done;

  always_comb begin
    set_vec          = '0;
    set_vec[B_OVRB]  = ev_ovr_b;
    set_vec[B_GPIO]  = ev_gpio;
    set_vec[B_DONE]  = ev_disp_done;
    set_vec[B_UNDER] = ev_disp_under;
    set_vec[B_MISS]  = fld_start & done_pending;
    set_vec[B_TICK]  = ev_tick & tc_mode & tick_en;
    set_vec[B_TCMP]  = ev_cmp & tc_mode & cmp_en;
  end
endmodule

// File: rtl/vport_irq_regs.sv
module vport_irq_regs
  import vport_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] IMPL = IMPL_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q
);
  logic          clr_wr;
  logic          mask_wr;
  logic [W-1:0]  clr_vec;

  assign clr_wr  = wr_en & ~wr_sel;
  assign mask_wr = wr_en & wr_sel;
  assign clr_vec = {W{clr_wr}} & wr_data & IMPL;

  for (genvar i = 0; i < W; i++) begin : g_bit
    vport_irq_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i] & IMPL[i]),
      .clr_i (clr_vec[i]),
      .q_o   (status_q[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                  mask_q[i] <= 1'b0;
      else if (mask_wr && IMPL[i]) mask_q[i] <= wr_data[i];
    end
  end

  // R6: a set bit with no clear aimed at it stays set
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~clr_vec) != '0) |=>
      ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));

  // R7: every qualified set lands, even under a same-edge clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & IMPL) != '0) |=> ((status_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

  // R8: unimplemented positions never hold a 1
  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~IMPL) == '0) && ((mask_q & ~IMPL) == '0));
endmodule

// File: rtl/vport_irq_stat.sv
module vport_irq_stat
  import vport_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         ev_ovr_b,
  input  logic         ev_gpio,
  input  logic         ev_disp_done,
  input  logic         ev_disp_under,
  input  logic         ev_tick,
  input  logic         ev_cmp,
  input  logic [1:0]   cap_mode,
  input  logic         tick_en,
  input  logic         cmp_en,
  input  logic         fld1_done,
  input  logic         fld2_done,
  input  logic         frm_done,
  input  logic         fld_start,
  output logic         irq
);
  logic [W-1:0] set_vec;
  logic [W-1:0] status_q;
  logic [W-1:0] mask_q;

  vport_irq_qual #(.W(W)) u_qual (
    .ev_ovr_b      (ev_ovr_b),
    .ev_gpio       (ev_gpio),
    .ev_disp_done  (ev_disp_done),
    .ev_disp_under (ev_disp_under),
    .ev_tick       (ev_tick),
    .ev_cmp        (ev_cmp),
    .cap_mode      (cap_mode),
    .tick_en       (tick_en),
    .cmp_en        (cmp_en),
    .fld1_done     (fld1_done),
    .fld2_done     (fld2_done),
    .frm_done      (frm_done),
    .fld_start     (fld_start),
    .set_vec       (set_vec)
  );

  vport_irq_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .status_q (status_q),
    .mask_q   (mask_q)
  );

  assign rd_data = rd_sel ? mask_q : status_q;
  assign irq     = |(status_q & mask_q);

  // R3: missed-acknowledge bit rises only after a field start with a done flag up
  assert_miss_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[B_MISS]) |-> $past(fld_start && (fld1_done || fld2_done || frm_done)));

  // R4: tick bit rises only in time-clock mode with its enable on
  assert_tick_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[B_TICK]) |-> $past(ev_tick && cap_mode == 2'd3 && tick_en));

  // R5: compare bit rises only in time-clock mode with its enable on
  assert_cmp_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[B_TCMP]) |-> $past(ev_cmp && cap_mode == 2'd3 && cmp_en));
endmodule

// File: tb/vport_irq_stat_tb.sv
`timescale 1ns/100ps
module vport_irq_stat_tb;
  localparam logic [31:0] IMPL = 32'h0003_7C00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ev_ovr_b = 0, ev_gpio = 0, ev_disp_done = 0, ev_disp_under = 0;
  logic        ev_tick = 0, ev_cmp = 0, tick_en = 0, cmp_en = 0;
  logic [1:0]  cap_mode = 2'd0;
  logic        fld1_done = 0, fld2_done = 0, frm_done = 0, fld_start = 0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_stat = '0;
  logic [31:0] m_mask = '0;

  always #2 clk = ~clk;

  vport_irq_stat u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ev_ovr_b(ev_ovr_b), .ev_gpio(ev_gpio),
    .ev_disp_done(ev_disp_done), .ev_disp_under(ev_disp_under), .ev_tick(ev_tick),
    .ev_cmp(ev_cmp), .cap_mode(cap_mode), .tick_en(tick_en), .cmp_en(cmp_en),
    .fld1_done(fld1_done), .fld2_done(fld2_done), .frm_done(frm_done),
    .fld_start(fld_start), .irq(irq)
  );

  function automatic logic [31:0] exp_set();
    logic [31:0] s = '0;
    s[17] = ev_ovr_b;
    s[16] = ev_gpio;
    s[13] = ev_disp_done;
    s[12] = ev_disp_under;
    s[14] = fld_start && (fld1_done || fld2_done || frm_done);
    s[11] = ev_tick && cap_mode == 2'd3 && tick_en;
    s[10] = ev_cmp && cap_mode == 2'd3 && cmp_en;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    wr_en = 0; wr_sel = 0; wr_data = '0;
    ev_ovr_b = 0; ev_gpio = 0; ev_disp_done = 0; ev_disp_under = 0;
    ev_tick = 0; ev_cmp = 0; fld_start = 0;
  endtask

  // One clock: advance model at the edge, compare 1 ns later
  task automatic step(input string req);
    logic [31:0] clr;
    @(posedge clk);
    clr = (wr_en && !wr_sel) ? (wr_data & IMPL) : '0;
    m_stat = (m_stat & ~clr) | exp_set();
    if (wr_en && wr_sel) m_mask = wr_data & IMPL;
    #1;
    rd_sel = 0; #0.2;
    chk(req, rd_data, m_stat);
    rd_sel = 1; #0.2;
    chk("R10", rd_data, m_mask);
    rd_sel = 0; #0.2;
    chk("R9", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    quiet();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_sel = 0; wr_data = '1;
    step("R6");
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #0.2;
    chk("R1", rd_data, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);
    rd_sel = 1; #0.2;
    chk("R1", rd_data, 32'd0);
    rd_sel = 0;

    // R10 / R8: enable word keeps only implemented bits
    wr_en = 1; wr_sel = 1; wr_data = '1;
    step("R10");
    rd_sel = 1; #0.2;
    chk("R8", rd_data & ~IMPL, 32'd0);
    rd_sel = 0;

    // R2: each plain strobe
    ev_ovr_b = 1;      step("R2");
    ev_gpio = 1;       step("R2");
    ev_disp_done = 1;  step("R2");
    ev_disp_under = 1; step("R2");
    chk("R2", rd_data & 32'h0003_3000, 32'h0003_3000);

    // R6: write of zeros changes nothing, then a single-bit clear
    wr_en = 1; wr_sel = 0; wr_data = '0; step("R6");
    wr_en = 1; wr_sel = 0; wr_data = 32'h0000_1000; step("R6");
    chk("R6", rd_data & 32'h0003_3000, 32'h0003_2000);
    clear_all();

    // R3: field start without flags, then with each flag
    fld_start = 1; step("R3");
    chk("R3", rd_data[14], 1'b0);
    fld1_done = 1; step("R3"); fld1_done = 0; step("R3");
    fld_start = 1; step("R3");
    chk("R3", rd_data[14], 1'b0);
    frm_done = 1; fld_start = 1; step("R3");
    chk("R3", rd_data[14], 1'b1);
    frm_done = 0; clear_all();
    fld2_done = 1; fld_start = 1; step("R3");
    chk("R3", rd_data[14], 1'b1);
    fld2_done = 0; clear_all();

    // R4 / R5: mode and enable gating
    for (int md = 0; md < 4; md++) begin
      cap_mode = 2'(md); tick_en = 1; cmp_en = 0;
      ev_tick = 1; ev_cmp = 1; step("R4");
      chk("R4", rd_data[11], md == 3);
      chk("R5", rd_data[10], 1'b0);
      clear_all();
      cap_mode = 2'(md); tick_en = 0; cmp_en = 1;
      ev_tick = 1; ev_cmp = 1; step("R5");
      chk("R5", rd_data[10], md == 3);
      chk("R4", rd_data[11], 1'b0);
      clear_all();
    end

    // R7: set and clear on the same bit at the same edge
    ev_gpio = 1; wr_en = 1; wr_sel = 0; wr_data = 32'h0001_0000; step("R7");
    chk("R7", rd_data[16], 1'b1);
    cap_mode = 2'd3; tick_en = 1;
    ev_tick = 1; wr_en = 1; wr_sel = 0; wr_data = '1; step("R7");
    chk("R7", rd_data[11], 1'b1);

    // R8: ones written everywhere leave unimplemented bits at 0
    wr_en = 1; wr_sel = 0; wr_data = 32'hFFFF_FFFF; step("R8");
    chk("R8", rd_data, 32'd0);

    // R9: irq follows enable of a single status bit
    wr_en = 1; wr_sel = 1; wr_data = 32'h0000_1000; step("R9");
    ev_disp_done = 1; step("R9");
    chk("R9", {31'd0, irq}, 32'd0);
    ev_disp_under = 1; step("R9");
    chk("R9", {31'd0, irq}, 32'd1);
    clear_all();

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      ev_ovr_b      = ($urandom % 5) == 0;
      ev_gpio       = ($urandom % 5) == 0;
      ev_disp_done  = ($urandom % 5) == 0;
      ev_disp_under = ($urandom % 5) == 0;
      ev_tick       = ($urandom % 3) == 0;
      ev_cmp        = ($urandom % 3) == 0;
      cap_mode      = 2'($urandom);
      tick_en       = 1'($urandom);
      cmp_en        = 1'($urandom);
      fld1_done     = ($urandom % 4) == 0;
      fld2_done     = ($urandom % 4) == 0;
      frm_done      = ($urandom % 4) == 0;
      fld_start     = ($urandom % 6) == 0;
      wr_en         = ($urandom % 4) == 0;
      wr_sel        = ($urandom % 3) == 0;
      wr_data       = $urandom;
      step("R6");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule